// File: doc/BRIEF.md
# External Interrupt Capture Unit

This block watches a small group of external input pins and turns trigger conditions on them into sticky per-pin request flags that an interrupt controller downstream can use. Each pin passes through a two-flop synchronizer. Its trigger is then selected by two configuration bits. One bit chooses between edge and level sensitivity. The other chooses the active direction: rising edge or high level, or falling edge or low level. A flag is set whenever its trigger occurs, regardless of any downstream enabling, so software can also poll the flags.

Flags are cleared by pulsing a one on the matching bit of a clear vector, and zero bits in that vector have no effect. In level mode the flag keeps setting again for as long as the active level is present, so a clear has no effect until the level goes away. Changing a pin's configuration drops any flag pending on that pin. This prevents the change itself from being reported as an event.

The block also holds an idle state that is entered on request. Idle ends by itself when a pin whose wake-enable bit is set has its flag raised. At that point a single-cycle wake pulse is produced.

Top module: `ext_irq_capture`

## Requirements
- R1: After a synchronous active-high reset, all flags are 0, the idle output is 0 and the wake output is 0.
- R2: A pin change driven between clock edges becomes visible on its flag after exactly the third rising clock edge, and not after the second. This delay comes from a two-flop synchronizer followed by the registered flag.
- R3: With mode bit 1 (edge) and polarity bit 1, a low-to-high transition sets the flag exactly once. The flag stays set after the pin returns low. A pin that stays high does not set the flag again after a clear.
- R4: With mode bit 1 and polarity bit 0, a high-to-low transition sets the flag, and a low-to-high transition does not.
- R5: With mode bit 0 (level) and polarity bit 1, the flag is set while the pin is high. A clear has no effect while the pin stays high. A clear after the pin has gone low drops the flag.
- R6: With mode bit 0 and polarity bit 0, the flag is set while the pin is low.
- R7: A one on bit i of the clear vector, held for one cycle, drops flag i after that edge. Zero bits leave the other flags unchanged.
- R8: Any change of a pin's mode or polarity bit clears that pin's pending flag on the next edge and leaves the other pins' flags unchanged.
- R9: A one-cycle idle request sets the idle output. While idle, a raised flag on a pin whose wake-enable bit is 1 clears idle on the next edge and drives the wake output high for exactly one cycle.
- R10: While idle, a raised flag on a pin whose wake-enable bit is 0 does not end idle.
- R11: The pins are independent. An event on one pin sets only that pin's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous external pins |
| cfg_edge_i | input | NUM_PINS | Per-pin mode: 1 edge, 0 level |
| cfg_pol_i | input | NUM_PINS | Per-pin polarity: 1 rising/high, 0 falling/low |
| wake_en_i | input | NUM_PINS | Per-pin permission to end idle |
| flag_clr_i | input | NUM_PINS | Write-one-to-clear strobe per flag |
| idle_req_i | input | 1 | One-cycle request to enter idle |
| irq_flag_o | output | NUM_PINS | Registered sticky flags, also the interrupt requests |
| idle_o | output | 1 | Idle state |
| wake_o | output | 1 | One-cycle pulse on exit from idle |

## Verification
The bench samples a flag after the second and after the third edge. A design with one synchronizer stage too few or too many fails one of those two samples. It leaves an edge-mode pin high after a clear to catch a detector that re-arms on level. It clears a level-mode flag while the level is still active to catch a clear that beats a set. It changes polarity with a flag pending, where a design without the configuration guard would keep the stale flag. On the idle side it tests a wake from a masked pin, which must not end idle, and checks that the wake pulse lasts exactly one cycle, since a stuck pulse would look like repeated wake events.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef struct packed {
    logic edge_mode;
    logic pol_high;
  } pin_cfg_t;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import ext_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     level_i,
  input  pin_cfg_t cfg_i,
  output logic     hit_o
);
  logic prev_q;
  logic rise, fall, active;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  always_comb begin
    rise   = level_i & ~prev_q;
    fall   = ~level_i & prev_q;
    active = cfg_i.pol_high ? level_i : ~level_i;
    if (cfg_i.edge_mode) hit_o = cfg_i.pol_high ? rise : fall;
    else                 hit_o = active;
  end
endmodule

// File: rtl/eic_flag.sv
module eic_flag
  import ext_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_cfg_t cfg_i,
  input  logic     hit_i,
  input  logic     clr_i,
  output logic     flag_o
);
  pin_cfg_t cfg_q;
  logic     flag_q;
  logic     cfg_chg;

  assign cfg_chg = (cfg_i != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cfg_q <= cfg_i;
      if (cfg_chg)    flag_q <= 1'b0;
      else if (hit_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_w1c_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && clr_i && !hit_i) |=> !flag_q);

  p_cfg_change_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> !flag_q);

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i && !cfg_chg) |=> flag_q);

  p_level_no_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !cfg_i.edge_mode && !cfg_chg && clr_i) |=> flag_q);
endmodule

// File: rtl/eic_wake.sv
module eic_wake #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] flag_i,
  input  logic [WIDTH-1:0] wake_en_i,
  input  logic             idle_req_i,
  output logic             idle_o,
  output logic             wake_o
);
  logic idle_q, wake_q;
  logic wake_cond;

  assign wake_cond = |(flag_i & wake_en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= idle_q & wake_cond;
      if (idle_q) idle_q <= ~wake_cond;
      else        idle_q <= idle_req_i;
    end
  end

  assign idle_o = idle_q;
  assign wake_o = wake_q;

  p_wake_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (idle_q && wake_cond) |=> (!idle_q && wake_q));

  p_wake_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (idle_q && !wake_cond) |=> idle_q);
endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] cfg_edge_i,
  input  logic [NUM_PINS-1:0] cfg_pol_i,
  input  logic [NUM_PINS-1:0] wake_en_i,
  input  logic [NUM_PINS-1:0] flag_clr_i,
  input  logic                idle_req_i,
  output logic [NUM_PINS-1:0] irq_flag_o,
  output logic                idle_o,
  output logic                wake_o
);
  localparam int unsigned STAGES_USED =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] flags;

  eic_sync #(.WIDTH(NUM_PINS), .STAGES(STAGES_USED)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(pin_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg.edge_mode = cfg_edge_i[p];
    assign cfg.pol_high  = cfg_pol_i[p];

    eic_detect u_det (
      .clk(clk), .rst(rst), .level_i(pin_sync[p]), .cfg_i(cfg), .hit_o(hit[p])
    );

    eic_flag u_flag (
      .clk(clk), .rst(rst), .cfg_i(cfg), .hit_i(hit[p]),
      .clr_i(flag_clr_i[p]), .flag_o(flags[p])
    );
  end

  eic_wake #(.WIDTH(NUM_PINS)) u_wake (
    .clk(clk), .rst(rst), .flag_i(flags), .wake_en_i(wake_en_i),
    .idle_req_i(idle_req_i), .idle_o(idle_o), .wake_o(wake_o)
  );

  assign irq_flag_o = flags;
endmodule

// File: tb/ext_irq_capture_tb.sv
module ext_irq_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pin_i = '0, cfg_edge_i = '1, cfg_pol_i = '1;
  logic [N-1:0] wake_en_i = '0, flag_clr_i = '0;
  logic idle_req_i = 1'b0;
  logic [N-1:0] irq_flag_o;
  logic idle_o, wake_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_capture #(.NUM_PINS(N), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .cfg_edge_i(cfg_edge_i),
    .cfg_pol_i(cfg_pol_i), .wake_en_i(wake_en_i), .flag_clr_i(flag_clr_i),
    .idle_req_i(idle_req_i), .irq_flag_o(irq_flag_o), .idle_o(idle_o),
    .wake_o(wake_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mask(input logic [N-1:0] m);
    flag_clr_i = m;
    tick(1);
    flag_clr_i = '0;
  endtask

  task automatic init_state();
    pin_i = '0; cfg_edge_i = '1; cfg_pol_i = '1; wake_en_i = '0;
    tick(4);
    clear_mask('1);
    tick(1);
  endtask

  task automatic t_reset();
    check("R1 flags", irq_flag_o, 0);
    check("R1 idle", idle_o, 0);
    check("R1 wake", wake_o, 0);
  endtask

  task automatic t_latency();
    init_state();
    pin_i[0] = 1'b1;
    tick(2);
    check("R2 not after 2 edges", irq_flag_o, 0);
    tick(1);
    check("R2 set after 3 edges", irq_flag_o, 4'b0001);
  endtask

  task automatic t_edge_rise();
    init_state();
    pin_i[1] = 1'b1; tick(4);
    check("R3 rise sets", irq_flag_o, 4'b0010);
    clear_mask(4'b0010); tick(3);
    check("R3 held high no re-set", irq_flag_o, 0);
    pin_i[1] = 1'b0; tick(1);
    pin_i[1] = 1'b1; tick(4);
    pin_i[1] = 1'b0; tick(4);
    check("R3 stays after return", irq_flag_o, 4'b0010);
    check("R11 only pin 1", irq_flag_o & 4'b1101, 0);
  endtask

  task automatic t_edge_fall();
    init_state();
    pin_i[2] = 1'b1; tick(4);
    check("R8 setup flag", irq_flag_o, 4'b0100);
    cfg_pol_i[2] = 1'b0; tick(1);
    check("R8 polarity change clears", irq_flag_o, 0);
    tick(3);
    check("R4 no set while high", irq_flag_o, 0);
    pin_i[2] = 1'b0; tick(4);
    check("R4 fall sets", irq_flag_o, 4'b0100);
    clear_mask(4'b0100);
    pin_i[2] = 1'b1; tick(4);
    check("R4 rise ignored", irq_flag_o, 0);
  endtask

  task automatic t_level_high();
    init_state();
    cfg_edge_i[3] = 1'b0; tick(2);
    pin_i[3] = 1'b1; tick(4);
    check("R5 high sets", irq_flag_o, 4'b1000);
    clear_mask(4'b1000); tick(1);
    check("R5 clear ignored while high", irq_flag_o, 4'b1000);
    pin_i[3] = 1'b0; tick(4);
    check("R5 still set after drop", irq_flag_o, 4'b1000);
    clear_mask(4'b1000);
    check("R5 clear after drop", irq_flag_o, 0);
  endtask

  task automatic t_level_low();
    init_state();
    cfg_edge_i[0] = 1'b0; cfg_pol_i[0] = 1'b0;
    tick(3);
    check("R6 low level sets", irq_flag_o, 4'b0001);
    pin_i[0] = 1'b1; tick(4);
    clear_mask(4'b0001);
    check("R6 clear once high", irq_flag_o, 0);
  endtask

  task automatic t_w1c();
    init_state();
    pin_i = 4'b0101; tick(4);
    check("R11 two pins", irq_flag_o, 4'b0101);
    clear_mask(4'b0000);
    check("R7 zero write no effect", irq_flag_o, 4'b0101);
    clear_mask(4'b0100);
    check("R7 one bit cleared", irq_flag_o, 4'b0001);
  endtask

  task automatic t_cfg_other();
    init_state();
    pin_i = 4'b0011; tick(4);
    cfg_edge_i[1] = 1'b0; cfg_pol_i[1] = 1'b0; tick(1);
    check("R8 other pin kept", irq_flag_o, 4'b0001);
  endtask

  task automatic t_wake();
    init_state();
    wake_en_i = 4'b0010;
    idle_req_i = 1'b1; tick(1); idle_req_i = 1'b0;
    check("R9 idle entered", idle_o, 1);
    pin_i[0] = 1'b1; tick(6);
    check("R10 masked pin keeps idle", idle_o, 1);
    check("R10 no wake", wake_o, 0);
    pin_i[1] = 1'b1; tick(3);
    check("R9 still idle at flag", idle_o, 1);
    tick(1);
    check("R9 idle cleared", idle_o, 0);
    check("R9 wake pulse", wake_o, 1);
    tick(1);
    check("R9 pulse one cycle", wake_o, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_latency();
    t_edge_rise();
    t_edge_fall();
    t_level_high();
    t_level_low();
    t_w1c();
    t_cfg_other();
    t_wake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule